// File: doc/BRIEF.md
# Three-Multiplier Complex Product Pipeline

This block multiplies a complex sample `x = a + jb` by a complex coefficient `w = C + jD`. A direct implementation needs four real multipliers. This one needs three. It forms the term `a*(C+D)` once and uses it in both outputs. The real output subtracts `(a+b)*D` from the shared term, and the imaginary output adds `(b-a)*C` to it. The arithmetic is full precision, so every signed input gives the exact product. There is no rounding, no saturation and no conjugation.

The datapath has three register stages:
- a pre-add stage that forms `C+D`, `a+b` and `b-a`;
- a product stage holding exactly three multipliers;
- a post-add stage that combines the products.

A qualifier travels with the data. The block accepts one new sample in every cycle. The data registers in each stage load only when the qualifier for that stage is high. On idle cycles the results stay at their last values.

Top module: `cmul3_top`

## Requirements
- R1: When `res_vld` is 1, `res_re` equals `a*C - b*D` exactly as a signed value `SW+CW+1` bits wide, where `a` = `x_re`, `b` = `x_im`, `C` = `w_re` and `D` = `w_im` of the accepted input.
- R2: When `res_vld` is 1, `res_im` equals `a*D + b*C` exactly as a signed value `SW+CW+1` bits wide.
- R3: Inputs at their most negative and most positive signed values give results identical to the four-product formula. For example, with all four inputs at the most negative value the real part is 0 and the imaginary part is `2^(SW+CW-1)`.
- R4: An input accepted at a rising edge with `in_vld` = 1 produces `res_vld` = 1 with its result after the third rising edge, counting the accepting edge as the first. Inputs on consecutive cycles give results on consecutive cycles.
- R5: `res_vld` is 1 only three edges after an accepted input, and is 0 otherwise.
- R6: While `res_vld` is 0, `res_re` and `res_im` keep the value of the most recent valid result. Inputs presented with `in_vld` = 0 never reach the outputs.
- R7: While `rst_n` is low, `res_vld`, `res_re` and `res_im` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample and coefficient are valid |
| x_re | input | SW | Sample real part `a`, signed |
| x_im | input | SW | Sample imaginary part `b`, signed |
| w_re | input | CW | Coefficient real part `C`, signed |
| w_im | input | CW | Coefficient imaginary part `D`, signed |
| res_vld | output | 1 | Result valid |
| res_re | output | SW+CW+1 | Real part of the product, signed |
| res_im | output | SW+CW+1 | Imaginary part of the product, signed |

## Verification
A result is due three rising edges after its input is accepted. The bench drives inputs on falling edges and keeps a three-slot model of expected results. At each falling edge, before it drives the next input, it compares the outputs with the slot that entered three cycles earlier. Idle cycles carry no slot. On those cycles the bench expects `res_vld` low and the previous result still on the outputs, which covers R5 and R6 in the same cycle counting.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

    // Register stages from input acceptance to result.
    localparam int unsigned CMUL3_STAGES = 3;

    // Default operand widths.
    localparam int unsigned CMUL3_SW_DEF = 16;
    localparam int unsigned CMUL3_CW_DEF = 16;

endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
    parameter int unsigned SW = 16,
    parameter int unsigned CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [SW-1:0]        x_re,
    input  logic [SW-1:0]        x_im,
    input  logic [CW-1:0]        w_re,
    input  logic [CW-1:0]        w_im,
    output logic                 pa_vld,
    output logic [SW-1:0]        pa_a,
    output logic [CW-1:0]        pa_c,
    output logic [CW-1:0]        pa_d,
    output logic [CW:0]          pa_cpd,
    output logic [SW:0]          pa_apb,
    output logic [SW:0]          pa_bma
);
    typedef struct packed {
        logic          vld;
        logic [SW-1:0] a;
        logic [CW-1:0] c;
        logic [CW-1:0] d;
        logic [CW:0]   cpd;
        logic [SW:0]   apb;
        logic [SW:0]   bma;
    } pa_st_t;

    pa_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.a   = x_re;
            st_d.c   = w_re;
            st_d.d   = w_im;
            // One extra bit keeps each sum and difference exact.
            st_d.cpd = {w_re[CW-1], w_re} + {w_im[CW-1], w_im};
            st_d.apb = {x_re[SW-1], x_re} + {x_im[SW-1], x_im};
            st_d.bma = {x_im[SW-1], x_im} - {x_re[SW-1], x_re};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pa_vld = st_q.vld;
    assign pa_a   = st_q.a;
    assign pa_c   = st_q.c;
    assign pa_d   = st_q.d;
    assign pa_cpd = st_q.cpd;
    assign pa_apb = st_q.apb;
    assign pa_bma = st_q.bma;

    // R4: an accepted input moves on by exactly one stage.
    a_r4_stage1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> pa_vld);
    // R5: no qualifier appears without an input.
    a_r5_stage1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !pa_vld);
    // R6: an idle input leaves the operands untouched.
    a_r6_stage1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(pa_a) && $stable(pa_cpd) && $stable(pa_bma)));
endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult #(
    parameter int unsigned SW = 16,
    parameter int unsigned CW = 16,
    localparam int unsigned PW = SW + CW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pa_vld,
    input  logic [SW-1:0]   pa_a,
    input  logic [CW-1:0]   pa_c,
    input  logic [CW-1:0]   pa_d,
    input  logic [CW:0]     pa_cpd,
    input  logic [SW:0]     pa_apb,
    input  logic [SW:0]     pa_bma,
    output logic            mp_vld,
    output logic [PW-1:0]   mp_shared,
    output logic [PW-1:0]   mp_re,
    output logic [PW-1:0]   mp_im
);
    typedef struct packed {
        logic          vld;
        logic [PW-1:0] shared;
        logic [PW-1:0] re;
        logic [PW-1:0] im;
    } mp_st_t;

    mp_st_t st_d, st_q;

    // Operands sign-extended to the product width, so that a PW-bit
    // product is exact modulo 2^PW.
    logic signed [PW-1:0] op_a, op_cpd, op_apb, op_d, op_bma, op_c;

    always_comb begin
        op_a   = {{(PW-SW){pa_a[SW-1]}}, pa_a};
        op_cpd = {{(PW-CW-1){pa_cpd[CW]}}, pa_cpd};
        op_apb = {{(PW-SW-1){pa_apb[SW]}}, pa_apb};
        op_d   = {{(PW-CW){pa_d[CW-1]}}, pa_d};
        op_bma = {{(PW-SW-1){pa_bma[SW]}}, pa_bma};
        op_c   = {{(PW-CW){pa_c[CW-1]}}, pa_c};
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = pa_vld;
        if (pa_vld) begin
            // The only three multipliers in the block.
            st_d.shared = op_a   * op_cpd;
            st_d.re     = op_apb * op_d;
            st_d.im     = op_bma * op_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mp_vld    = st_q.vld;
    assign mp_shared = st_q.shared;
    assign mp_re     = st_q.re;
    assign mp_im     = st_q.im;

    // R4: the product stage passes the qualifier on by one cycle.
    a_r4_stage2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        pa_vld |=> mp_vld);
    // R6: the products hold while the stage is idle.
    a_r6_stage2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_vld |=> ($stable(mp_shared) && $stable(mp_re) && $stable(mp_im)));
endmodule

// File: rtl/cmul3_postadd.sv
module cmul3_postadd #(
    parameter int unsigned PW = 33
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mp_vld,
    input  logic [PW-1:0]   mp_shared,
    input  logic [PW-1:0]   mp_re,
    input  logic [PW-1:0]   mp_im,
    output logic            po_vld,
    output logic [PW-1:0]   po_re,
    output logic [PW-1:0]   po_im
);
    typedef struct packed {
        logic          vld;
        logic [PW-1:0] re;
        logic [PW-1:0] im;
    } po_st_t;

    po_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = mp_vld;
        if (mp_vld) begin
            // The final value fits in PW bits, so wrapping
            // intermediates still give the exact result.
            st_d.re = mp_shared - mp_re;
            st_d.im = mp_shared + mp_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign po_vld = st_q.vld;
    assign po_re  = st_q.re;
    assign po_im  = st_q.im;

    // R6: the results hold across idle cycles.
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_vld |=> ($stable(po_re) && $stable(po_im)));
    // R5: the result qualifier follows the product qualifier exactly.
    a_r5_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_vld |=> !po_vld);
endmodule

// File: rtl/cmul3_top.sv
module cmul3_top
    import cmul3_pkg::*;
#(
    parameter int unsigned SW = CMUL3_SW_DEF,
    parameter int unsigned CW = CMUL3_CW_DEF,
    localparam int unsigned PW = SW + CW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [SW-1:0]   x_re,
    input  logic [SW-1:0]   x_im,
    input  logic [CW-1:0]   w_re,
    input  logic [CW-1:0]   w_im,
    output logic            res_vld,
    output logic [PW-1:0]   res_re,
    output logic [PW-1:0]   res_im
);
    logic          pa_vld;
    logic [SW-1:0] pa_a;
    logic [CW-1:0] pa_c, pa_d;
    logic [CW:0]   pa_cpd;
    logic [SW:0]   pa_apb, pa_bma;
    logic          mp_vld;
    logic [PW-1:0] mp_shared, mp_re, mp_im;

    cmul3_preadd #(.SW(SW), .CW(CW)) u_preadd (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .x_re   (x_re),
        .x_im   (x_im),
        .w_re   (w_re),
        .w_im   (w_im),
        .pa_vld (pa_vld),
        .pa_a   (pa_a),
        .pa_c   (pa_c),
        .pa_d   (pa_d),
        .pa_cpd (pa_cpd),
        .pa_apb (pa_apb),
        .pa_bma (pa_bma)
    );

    cmul3_mult #(.SW(SW), .CW(CW)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .pa_vld    (pa_vld),
        .pa_a      (pa_a),
        .pa_c      (pa_c),
        .pa_d      (pa_d),
        .pa_cpd    (pa_cpd),
        .pa_apb    (pa_apb),
        .pa_bma    (pa_bma),
        .mp_vld    (mp_vld),
        .mp_shared (mp_shared),
        .mp_re     (mp_re),
        .mp_im     (mp_im)
    );

    cmul3_postadd #(.PW(PW)) u_postadd (
        .clk       (clk),
        .rst_n     (rst_n),
        .mp_vld    (mp_vld),
        .mp_shared (mp_shared),
        .mp_re     (mp_re),
        .mp_im     (mp_im),
        .po_vld    (res_vld),
        .po_re     (res_re),
        .po_im     (res_im)
    );

    // Four-product formula, used only by the checks below.
    function automatic logic [PW-1:0] four_re(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                              input logic [CW-1:0] c, input logic [CW-1:0] d);
        logic signed [PW-1:0] ea, eb, ec, ed;
        ea = {{(PW-SW){a[SW-1]}}, a};
        eb = {{(PW-SW){b[SW-1]}}, b};
        ec = {{(PW-CW){c[CW-1]}}, c};
        ed = {{(PW-CW){d[CW-1]}}, d};
        return ea * ec - eb * ed;
    endfunction

    function automatic logic [PW-1:0] four_im(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                              input logic [CW-1:0] c, input logic [CW-1:0] d);
        logic signed [PW-1:0] ea, eb, ec, ed;
        ea = {{(PW-SW){a[SW-1]}}, a};
        eb = {{(PW-SW){b[SW-1]}}, b};
        ec = {{(PW-CW){c[CW-1]}}, c};
        ed = {{(PW-CW){d[CW-1]}}, d};
        return ea * ed + eb * ec;
    endfunction

    // R1: the real result matches the four-product formula three cycles later.
    a_r1_real_exact: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_re == $past(four_re(x_re, x_im, w_re, w_im), 3));
    // R2: the imaginary result matches the four-product formula three cycles later.
    a_r2_imag_exact: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_im == $past(four_im(x_re, x_im, w_re, w_im), 3));
    // R4: three register stages from acceptance to result.
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pa_vld, 2) && $past(in_vld, 3) |-> res_vld);
    // R7: all outputs are cleared while reset is held.
    always_comb begin
        if (!rst_n) a_r7_reset_clear: assert (!res_vld && res_re == '0 && res_im == '0);
    end
endmodule

// File: tb/cmul3_top_bench.sv
module cmul3_top_bench;
    localparam int SW = 16;
    localparam int CW = 16;
    localparam int PW = SW + CW + 1;
    localparam int WATCHDOG_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [SW-1:0] x_re = '0, x_im = '0;
    logic [CW-1:0] w_re = '0, w_im = '0;
    logic          res_vld;
    logic [PW-1:0] res_re, res_im;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Expected-result pipeline: slot 1 is the newest input.
    bit      sl_v   [1:3];
    bit      sl_cor [1:3];
    longint  sl_re  [1:3];
    longint  sl_im  [1:3];
    longint  last_re = 0, last_im = 0;

    always #10 clk = ~clk;

    cmul3_top #(.SW(SW), .CW(CW)) u_cmul3_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .x_re    (x_re),
        .x_im    (x_im),
        .w_re    (w_re),
        .w_im    (w_im),
        .res_vld (res_vld),
        .res_re  (res_re),
        .res_im  (res_im)
    );

    function automatic longint sx_s(input logic [SW-1:0] v);
        return longint'($signed(v));
    endfunction
    function automatic longint sx_c(input logic [CW-1:0] v);
        return longint'($signed(v));
    endfunction
    function automatic longint sx_o(input logic [PW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One falling edge: compare the outputs with slot 3, shift, then drive the next input.
    task automatic step(input bit v, input logic [SW-1:0] a, input logic [SW-1:0] b,
                        input logic [CW-1:0] c, input logic [CW-1:0] d, input bit corner);
        @(negedge clk);
        check(sl_v[3] ? "R4 valid" : "R5 valid", longint'(res_vld), longint'(sl_v[3]));
        if (sl_v[3]) begin
            last_re = sl_re[3];
            last_im = sl_im[3];
            check(sl_cor[3] ? "R3 real" : "R1 real", sx_o(res_re), last_re);
            check(sl_cor[3] ? "R3 imag" : "R2 imag", sx_o(res_im), last_im);
        end else begin
            check("R6 hold real", sx_o(res_re), last_re);
            check("R6 hold imag", sx_o(res_im), last_im);
        end
        for (int k = 3; k > 1; k--) begin
            sl_v[k] = sl_v[k-1]; sl_cor[k] = sl_cor[k-1];
            sl_re[k] = sl_re[k-1]; sl_im[k] = sl_im[k-1];
        end
        sl_v[1]   = v;
        sl_cor[1] = corner;
        sl_re[1]  = sx_s(a) * sx_c(c) - sx_s(b) * sx_c(d);
        sl_im[1]  = sx_s(a) * sx_c(d) + sx_s(b) * sx_c(c);
        in_vld = v; x_re = a; x_im = b; w_re = c; w_im = d;
    endtask

    initial begin
        logic [SW-1:0] smin, smax;
        logic [CW-1:0] cmin, cmax;
        smin = {1'b1, {(SW-1){1'b0}}};
        smax = {1'b0, {(SW-1){1'b1}}};
        cmin = {1'b1, {(CW-1){1'b0}}};
        cmax = {1'b0, {(CW-1){1'b1}}};
        void'($urandom(32'd20240611));
        for (int k = 1; k <= 3; k++) begin
            sl_v[k] = 0; sl_cor[k] = 0; sl_re[k] = 0; sl_im[k] = 0;
        end
        // R7: reset state, with an active input held at the pins.
        in_vld = 1'b1; x_re = smin; x_im = smax; w_re = cmin; w_im = cmax;
        repeat (3) @(negedge clk);
        check("R7 valid", longint'(res_vld), 0);
        check("R7 real", sx_o(res_re), 0);
        check("R7 imag", sx_o(res_im), 0);
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3: extreme values, back to back.
        step(1, smin, smin, cmin, cmin, 1);
        step(1, smax, smax, cmax, cmax, 1);
        step(1, smin, smax, cmin, cmax, 1);
        step(1, smax, smin, cmax, cmin, 1);
        step(1, smin, smin, cmax, cmin, 1);
        step(1, smin, '0, cmin, '0, 1);
        step(1, '0, smin, '0, cmin, 1);
        // R6: garbage presented with in_vld low must not reach the outputs.
        step(0, smax, smin, cmin, cmin, 0);
        step(0, 16'h1234, 16'h8001, 16'h7ffe, 16'h0003, 0);
        step(0, '0, '0, '0, '0, 0);
        step(0, '0, '0, '0, '0, 0);
        // R1/R2: simple directed values.
        step(1, 16'd3, 16'd4, 16'd5, 16'hfffe, 0);
        step(1, 16'hffff, 16'd0, 16'd0, 16'd1, 0);
        // R4/R5: random traffic with random gaps.
        for (int n = 0; n < 3000; n++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, SW'($urandom), SW'($urandom), CW'($urandom), CW'($urandom), 0);
        end
        for (int n = 0; n < 4; n++) step(0, '0, '0, '0, '0, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule